// File: doc/BRIEF.md
# Translated Two-Level Lookup: Set-Associative TLB Feeding a Physically Tagged Data Cache

This block turns a 35-bit virtual byte address into a 32-bit physical address and reads one 32-bit word from a two-way data cache, all in one registered lookup. The address first goes to an eight-way, 32-set translation buffer. The buffer's hit vector is one-hot, and it picks the physical page number of the matching way. That page number is joined to the untranslated 14-bit page offset to form the physical address. The physical address then sets the index and the tag for a 64 KB, two-way cache with 128-byte lines. That cache is indexed and tagged from the physical address.

Two fill ports load the contents. One port writes a single translation. The other writes a whole cache line together with its tag. The translation buffer picks the way to replace with a round-robin pointer kept for each set. The cache keeps one least-recently-used bit for each set. When a lookup misses, the block does nothing more: it does not walk page tables and it does not fetch from memory. The surrounding logic fills the entry and then repeats the lookup.

Top module: `vtcache_top`

## Requirements
- R1: After a synchronous reset, every translation and cache entry is invalid. All outputs read zero, and the first lookup misses in both structures.
- R2: The page number is va[34:14]. Bits va[18:14] select the translation set and va[34:19] is the stored tag. A translation hits only when a valid way in that set holds the same tag.
- R3: On a translation hit, pa_o equals {ppn, va[13:0]}, with the 18-bit page number above the 14-bit offset. On a translation miss, pa_o is zero.
- R4: Each translation set has a round-robin pointer that starts at way 0 after reset and advances by one after every fill to that set. The ninth fill to a set replaces the first one.
- R5: The cache decodes the physical address as follows: pa[6:0] is the byte offset, pa[14:7] selects one of 256 sets, and pa[31:15] is the 17-bit tag compared against both ways.
- R6: A cache hit requires a translation hit. When the translation misses, cache_hit_o is low and data_o is zero, even if a matching line is present. On any cache miss, data_o is zero.
- R7: On a cache hit, pa[6:2] selects word k of the line. Word k is line bits [32k+31:32k].
- R8: Each cache set has an LRU bit that names the victim way. It is 0 after reset. A hit or a fill in way w sets it to the other way. A fill writes into the way the bit names.
- R9: Lookup results are registered. When lookup_i is high at a clock edge, rsp_valid_o and the result outputs update at that edge. Without a lookup, rsp_valid_o is low and the result outputs keep their values.
- R10: At most one way matches in each structure.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_i | input | 1 | Lookup strobe |
| va_i | input | 35 | Virtual byte address to look up |
| tfill_i | input | 1 | Write one translation |
| tfill_vpn_i | input | 21 | Page number of the translation being written |
| tfill_ppn_i | input | 18 | Physical page number of the translation being written |
| cfill_i | input | 1 | Write one cache line |
| cfill_pa_i | input | 32 | Physical address that gives the line's set and tag |
| cfill_line_i | input | 1024 | Line contents, word k in bits [32k+31:32k] |
| rsp_valid_o | output | 1 | High for the cycle after a lookup strobe |
| tlb_hit_o | output | 1 | Translation hit |
| pa_o | output | 32 | Translated physical address |
| cache_hit_o | output | 1 | Data cache hit |
| data_o | output | 32 | Selected data word |

## Verification
The bench builds the block with its default parameters: 35-bit virtual and 32-bit physical addresses, 8 ways by 32 sets in the translation buffer, and 256 sets of 128-byte lines in the cache. With these values the way-eviction corners are cheap to reach. Nine fills to one translation set wrap the round-robin pointer. Three physical pages whose page numbers differ only above bit 0 fall into the same cache set, so they are enough to exercise the LRU choice. A reference model in the bench tracks tags, valid bits, pointers and LRU bits, and predicts every lookup from that model.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    localparam int unsigned DEF_VA_W       = 35;
    localparam int unsigned DEF_PA_W       = 32;
    localparam int unsigned DEF_PAGE_W     = 14;
    localparam int unsigned DEF_TLB_WAYS   = 8;
    localparam int unsigned DEF_TLB_SETS   = 32;
    localparam int unsigned DEF_C_SETS     = 256;
    localparam int unsigned DEF_LINE_BYTES = 128;
    localparam int unsigned DEF_WORD_W     = 32;

    // one-bit replacement: the way that was not just touched
    function automatic logic other_way(input logic w);
        return ~w;
    endfunction

endpackage

// File: rtl/vtc_tlb.sv
module vtc_tlb #(
    parameter int unsigned VPN_W = 21,
    parameter int unsigned PPN_W = 18,
    parameter int unsigned WAYS  = 8,
    parameter int unsigned SETS  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit_o,
    output logic [PPN_W-1:0] ppn_o,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int unsigned SET_W = $clog2(SETS);
    localparam int unsigned TAG_W = VPN_W - SET_W;
    localparam int unsigned WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAY_W-1:0] rr_q    [SETS];

    logic [SET_W-1:0] lset, fset;
    logic [TAG_W-1:0] ltag, ftag;
    logic [WAYS-1:0]  match;

    assign lset = look_vpn[SET_W-1:0];
    assign ltag = look_vpn[VPN_W-1:SET_W];
    assign fset = fill_vpn[SET_W-1:0];
    assign ftag = fill_vpn[VPN_W-1:SET_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lset][w] && (tag_q[lset][w] == ltag);
    end

    always_comb begin
        ppn_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            ppn_o = ppn_o | ({PPN_W{match[w]}} & ppn_q[lset][w]);
        end
    end

    assign hit_o = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else if (fill_en) begin
            tag_q[fset][rr_q[fset]]   <= ftag;
            ppn_q[fset][rr_q[fset]]   <= fill_ppn;
            valid_q[fset][rr_q[fset]] <= 1'b1;
            rr_q[fset]                <= WAY_W'(rr_q[fset] + 1'b1);
        end
    end

    AST_TLB_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R10

    AST_TLB_RR_STEP: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> rr_q[$past(fset)] == WAY_W'($past(rr_q[fset]) + 1'b1)); // R4

endmodule

// File: rtl/vtc_dcache.sv
module vtc_dcache #(
    parameter int unsigned PA_W       = 32,
    parameter int unsigned SETS       = 256,
    parameter int unsigned LINE_BYTES = 128,
    parameter int unsigned WORD_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     look_en,
    input  logic                     xlat_ok,
    input  logic [PA_W-1:0]          look_pa,
    output logic                     hit_o,
    output logic [WORD_W-1:0]        word_o,
    input  logic                     fill_en,
    input  logic [PA_W-1:0]          fill_pa,
    input  logic [LINE_BYTES*8-1:0]  fill_line
);
    import vtc_pkg::*;

    localparam int unsigned WAYS   = 2;
    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W  = $clog2(SETS);
    localparam int unsigned TAG_W  = PA_W - OFS_W - IDX_W;
    localparam int unsigned BSEL_W = $clog2(WORD_W / 8);
    localparam int unsigned WSEL_W = OFS_W - BSEL_W;

    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] line_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic              lru_q   [SETS];

    logic [IDX_W-1:0]  lidx, fidx;
    logic [TAG_W-1:0]  ltag, ftag;
    logic [WSEL_W-1:0] wsel;
    logic [WAYS-1:0]   match;
    logic [LINE_W-1:0] sel_line;
    logic              any_match;
    logic              victim;

    assign lidx = look_pa[OFS_W +: IDX_W];
    assign ltag = look_pa[PA_W-1 -: TAG_W];
    assign wsel = look_pa[BSEL_W +: WSEL_W];
    assign fidx = fill_pa[OFS_W +: IDX_W];
    assign ftag = fill_pa[PA_W-1 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lidx][w] && (tag_q[lidx][w] == ltag);
    end

    always_comb begin
        sel_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            sel_line = sel_line | ({LINE_W{match[w]}} & line_q[lidx][w]);
        end
    end

    assign any_match = |match;
    assign hit_o     = xlat_ok && any_match;
    assign word_o    = hit_o ? sel_line[wsel*WORD_W +: WORD_W] : '0;
    assign victim    = lru_q[fidx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (look_en && hit_o) begin
                lru_q[lidx] <= other_way(match[1]);
            end
            if (fill_en) begin
                tag_q[fidx][victim]   <= ftag;
                line_q[fidx][victim]  <= fill_line;
                valid_q[fidx][victim] <= 1'b1;
                lru_q[fidx]           <= other_way(victim);
            end
        end
    end

    AST_CACHE_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R10

    AST_CACHE_LRU_FILL: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> lru_q[$past(fidx)] == ~$past(lru_q[fidx])); // R8

    AST_CACHE_HIT_GATED: assert property (@(posedge clk) disable iff (rst)
        !xlat_ok |-> !hit_o && word_o == '0); // R6

endmodule

// File: rtl/vtcache_top.sv
module vtcache_top #(
    parameter int unsigned VA_W       = vtc_pkg::DEF_VA_W,
    parameter int unsigned PA_W       = vtc_pkg::DEF_PA_W,
    parameter int unsigned PAGE_W     = vtc_pkg::DEF_PAGE_W,
    parameter int unsigned TLB_WAYS   = vtc_pkg::DEF_TLB_WAYS,
    parameter int unsigned TLB_SETS   = vtc_pkg::DEF_TLB_SETS,
    parameter int unsigned C_SETS     = vtc_pkg::DEF_C_SETS,
    parameter int unsigned LINE_BYTES = vtc_pkg::DEF_LINE_BYTES,
    parameter int unsigned WORD_W     = vtc_pkg::DEF_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lookup_i,
    input  logic [VA_W-1:0]           va_i,
    input  logic                      tfill_i,
    input  logic [VA_W-PAGE_W-1:0]    tfill_vpn_i,
    input  logic [PA_W-PAGE_W-1:0]    tfill_ppn_i,
    input  logic                      cfill_i,
    input  logic [PA_W-1:0]           cfill_pa_i,
    input  logic [LINE_BYTES*8-1:0]   cfill_line_i,
    output logic                      rsp_valid_o,
    output logic                      tlb_hit_o,
    output logic [PA_W-1:0]           pa_o,
    output logic                      cache_hit_o,
    output logic [WORD_W-1:0]         data_o
);
    localparam int unsigned VPN_W = VA_W - PAGE_W;
    localparam int unsigned PPN_W = PA_W - PAGE_W;

    logic              t_hit;
    logic [PPN_W-1:0]  t_ppn;
    logic [PA_W-1:0]   pa_c;
    logic              c_hit;
    logic [WORD_W-1:0] c_word;

    vtc_tlb #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .WAYS(TLB_WAYS), .SETS(TLB_SETS)
    ) u_tlb (
        .clk(clk), .rst(rst),
        .look_vpn(va_i[VA_W-1:PAGE_W]),
        .hit_o(t_hit), .ppn_o(t_ppn),
        .fill_en(tfill_i), .fill_vpn(tfill_vpn_i), .fill_ppn(tfill_ppn_i)
    );

    assign pa_c = t_hit ? {t_ppn, va_i[PAGE_W-1:0]} : '0;

    vtc_dcache #(
        .PA_W(PA_W), .SETS(C_SETS), .LINE_BYTES(LINE_BYTES), .WORD_W(WORD_W)
    ) u_dc (
        .clk(clk), .rst(rst),
        .look_en(lookup_i), .xlat_ok(t_hit), .look_pa(pa_c),
        .hit_o(c_hit), .word_o(c_word),
        .fill_en(cfill_i), .fill_pa(cfill_pa_i), .fill_line(cfill_line_i)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            tlb_hit_o   <= 1'b0;
            pa_o        <= '0;
            cache_hit_o <= 1'b0;
            data_o      <= '0;
        end else begin
            rsp_valid_o <= lookup_i;
            if (lookup_i) begin
                tlb_hit_o   <= t_hit;
                pa_o        <= pa_c;
                cache_hit_o <= c_hit;
                data_o      <= c_word;
            end
        end
    end

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        lookup_i |=> rsp_valid_o); // R9

    AST_RSP_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lookup_i |=> !rsp_valid_o && $stable(pa_o) && $stable(data_o)); // R9

    AST_CHIT_NEEDS_THIT: assert property (@(posedge clk) disable iff (rst)
        cache_hit_o |-> tlb_hit_o); // R6

    AST_PA_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (rst)
        lookup_i && t_hit |=> pa_o[PAGE_W-1:0] == $past(va_i[PAGE_W-1:0])); // R3

    AST_MISS_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o && !cache_hit_o |-> data_o == '0); // R6

endmodule

// File: tb/sim_vtcache_top.sv
module sim_vtcache_top;
    localparam int TW = 8, TS = 32, CS = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lookup_i = 1'b0;
    logic [34:0] va_i = '0;
    logic tfill_i = 1'b0;
    logic [20:0] tfill_vpn_i = '0;
    logic [17:0] tfill_ppn_i = '0;
    logic cfill_i = 1'b0;
    logic [31:0] cfill_pa_i = '0;
    logic [1023:0] cfill_line_i = '0;
    logic rsp_valid_o, tlb_hit_o, cache_hit_o;
    logic [31:0] pa_o, data_o;

    int checks = 0;
    int fails  = 0;

    bit [15:0]   m_ttag [TS][TW];
    bit [17:0]   m_tppn [TS][TW];
    bit          m_tv   [TS][TW];
    int          m_rr   [TS];
    bit [16:0]   m_ctag [CS][2];
    bit [1023:0] m_line [CS][2];
    bit          m_cv   [CS][2];
    bit          m_lru  [CS];

    always #5 clk = ~clk;

    vtcache_top u0 (
        .clk(clk), .rst(rst), .lookup_i(lookup_i), .va_i(va_i),
        .tfill_i(tfill_i), .tfill_vpn_i(tfill_vpn_i), .tfill_ppn_i(tfill_ppn_i),
        .cfill_i(cfill_i), .cfill_pa_i(cfill_pa_i), .cfill_line_i(cfill_line_i),
        .rsp_valid_o(rsp_valid_o), .tlb_hit_o(tlb_hit_o), .pa_o(pa_o),
        .cache_hit_o(cache_hit_o), .data_o(data_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [34:0] mk_va(input bit [15:0] tag, input bit [4:0] set,
                                          input bit [13:0] off);
        return {tag, set, off};
    endfunction

    function automatic logic [1023:0] mk_line(input bit [15:0] seed);
        logic [1023:0] l;
        for (int k = 0; k < 32; k++) l[k*32 +: 32] = {seed, 16'(k)};
        return l;
    endfunction

    task automatic model_tfill(input bit [20:0] vpn, input bit [17:0] ppn);
        int s = int'(vpn[4:0]);
        m_ttag[s][m_rr[s]] = vpn[20:5];
        m_tppn[s][m_rr[s]] = ppn;
        m_tv[s][m_rr[s]]   = 1'b1;
        m_rr[s] = (m_rr[s] + 1) % TW;
    endtask

    task automatic tfill(input bit [20:0] vpn, input bit [17:0] ppn);
        @(negedge clk);
        tfill_i = 1'b1; tfill_vpn_i = vpn; tfill_ppn_i = ppn;
        @(negedge clk);
        tfill_i = 1'b0;
        model_tfill(vpn, ppn);
    endtask

    task automatic cfill(input bit [31:0] pa, input bit [1023:0] line);
        int ix = int'(pa[14:7]);
        int v;
        @(negedge clk);
        cfill_i = 1'b1; cfill_pa_i = pa; cfill_line_i = line;
        @(negedge clk);
        cfill_i = 1'b0;
        v = int'(m_lru[ix]);
        m_ctag[ix][v] = pa[31:15];
        m_line[ix][v] = line;
        m_cv[ix][v]   = 1'b1;
        m_lru[ix]     = ~m_lru[ix];
    endtask

    // Predict from model, perform one lookup, compare all four results.
    task automatic lookup(input logic [34:0] va, input string req,
                          input bit with_tfill = 1'b0, input bit [20:0] fvpn = '0,
                          input bit [17:0] fppn = '0);
        int s = int'(va[18:14]);
        bit e_th = 1'b0, e_ch = 1'b0;
        bit [17:0] e_ppn = '0;
        bit [31:0] e_pa = '0, e_data = '0;
        int ix, hw;
        for (int w = 0; w < TW; w++)
            if (m_tv[s][w] && m_ttag[s][w] == va[34:19]) begin e_th = 1'b1; e_ppn = m_tppn[s][w]; end
        if (e_th) e_pa = {e_ppn, va[13:0]};
        ix = int'(e_pa[14:7]);
        hw = 0;
        if (e_th)
            for (int w = 0; w < 2; w++)
                if (m_cv[ix][w] && m_ctag[ix][w] == e_pa[31:15]) begin e_ch = 1'b1; hw = w; end
        if (e_ch) e_data = m_line[ix][hw][int'(e_pa[6:2])*32 +: 32];
        @(negedge clk);
        lookup_i = 1'b1; va_i = va;
        if (with_tfill) begin tfill_i = 1'b1; tfill_vpn_i = fvpn; tfill_ppn_i = fppn; end
        @(negedge clk);
        lookup_i = 1'b0; tfill_i = 1'b0;
        if (with_tfill) model_tfill(fvpn, fppn);
        if (e_ch) m_lru[ix] = (hw == 0);
        check(rsp_valid_o == 1'b1, req, "rsp_valid", 64'(rsp_valid_o), 64'd1);
        check(tlb_hit_o == e_th, req, "tlb_hit", 64'(tlb_hit_o), 64'(e_th));
        check(pa_o == e_pa, req, "pa", 64'(pa_o), 64'(e_pa));
        check(cache_hit_o == e_ch, req, "cache_hit", 64'(cache_hit_o), 64'(e_ch));
        check(data_o == e_data, req, "data", 64'(data_o), 64'(e_data));
    endtask

    task automatic t_reset;
        check(rsp_valid_o == 0 && tlb_hit_o == 0 && cache_hit_o == 0, "R1", "flags after reset",
              64'({rsp_valid_o, tlb_hit_o, cache_hit_o}), 64'd0);
        check(pa_o == 0 && data_o == 0, "R1", "pa/data after reset", 64'({pa_o, data_o}), 64'd0);
        lookup(mk_va(16'h1234, 5'd3, 14'h0040), "R1");
    endtask

    task automatic t_translate;
        tfill({16'hABCD, 5'd7}, 18'h2_5A5A);
        lookup(mk_va(16'hABCD, 5'd7, 14'h3FFF), "R3");
        lookup(mk_va(16'hABCD, 5'd7, 14'h0000), "R3");
        lookup(mk_va(16'hABCC, 5'd7, 14'h0100), "R2");  // same set, other tag
        lookup(mk_va(16'hABCD, 5'd8, 14'h0100), "R2");  // same tag, other set
        check(tlb_hit_o == 1'b0, "R2", "other set misses", 64'(tlb_hit_o), 64'd0);
    endtask

    task automatic t_cache_words;
        tfill({16'h0011, 5'd1}, 18'h0_0010);
        cfill({18'h0_0010, 14'h0080}, mk_line(16'hC0DE));
        lookup(mk_va(16'h0011, 5'd1, 14'h0080), "R7");  // word 0
        lookup(mk_va(16'h0011, 5'd1, 14'h00FC), "R7");  // word 31
        lookup(mk_va(16'h0011, 5'd1, 14'h00A6), "R7");  // word 9, byte bits ignored
        check(data_o == {16'hC0DE, 16'd9}, "R7", "word 9 value", 64'(data_o), 64'({16'hC0DE, 16'd9}));
        lookup(mk_va(16'h0011, 5'd1, 14'h0100), "R5");  // next set: miss
    endtask

    task automatic t_tlb_gate;
        cfill({18'h0_0000, 14'h0200}, mk_line(16'hBEEF));  // PA 0x200 cached
        lookup(mk_va(16'h7777, 5'd0, 14'h0200), "R6");     // untranslated va
        check(cache_hit_o == 1'b0 && data_o == 0, "R6", "miss suppresses data",
              64'({cache_hit_o, data_o}), 64'd0);
    endtask

    task automatic t_lru;
        // ppn 0x20/0x40/0x60 with offset 0x0300 share cache set 6, distinct tags
        tfill({16'h0100, 5'd2}, 18'h0_0020);
        tfill({16'h0200, 5'd2}, 18'h0_0040);
        tfill({16'h0300, 5'd2}, 18'h0_0060);
        cfill({18'h0_0020, 14'h0300}, mk_line(16'hAAAA));
        cfill({18'h0_0040, 14'h0300}, mk_line(16'hBBBB));
        lookup(mk_va(16'h0100, 5'd2, 14'h0300), "R8");   // hit A, B becomes victim
        cfill({18'h0_0060, 14'h0300}, mk_line(16'hCCCC));
        lookup(mk_va(16'h0200, 5'd2, 14'h0304), "R8");   // B evicted
        check(cache_hit_o == 1'b0, "R8", "victim replaced", 64'(cache_hit_o), 64'd0);
        lookup(mk_va(16'h0100, 5'd2, 14'h0308), "R8");
        lookup(mk_va(16'h0300, 5'd2, 14'h030C), "R8");
    endtask

    task automatic t_tlb_rr;
        for (int i = 0; i < 9; i++) tfill({16'(16'h4000 + i), 5'd20}, 18'(18'h1000 + i));
        lookup(mk_va(16'h4000, 5'd20, 14'h0010), "R4");  // first one replaced
        check(tlb_hit_o == 1'b0, "R4", "ninth fill evicts first", 64'(tlb_hit_o), 64'd0);
        lookup(mk_va(16'h4001, 5'd20, 14'h0010), "R4");
        lookup(mk_va(16'h4008, 5'd20, 14'h0010), "R4");
    endtask

    task automatic t_hold;
        logic [31:0] keep;
        lookup(mk_va(16'hABCD, 5'd7, 14'h1234), "R9");
        keep = pa_o;
        @(negedge clk); @(negedge clk);
        check(rsp_valid_o == 1'b0, "R9", "rsp_valid idle", 64'(rsp_valid_o), 64'd0);
        check(pa_o == keep && tlb_hit_o == 1'b1, "R9", "result held", 64'(pa_o), 64'(keep));
    endtask

    task automatic t_same_cycle;
        lookup(mk_va(16'h5555, 5'd9, 14'h0004), "R11", 1'b1, {16'h5555, 5'd9}, 18'h3_0001);
        check(tlb_hit_o == 1'b0, "R11", "old contents seen", 64'(tlb_hit_o), 64'd0);
        lookup(mk_va(16'h5555, 5'd9, 14'h0004), "R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_translate();
        t_cache_words();
        t_tlb_gate();
        t_lru();
        t_tlb_rr();
        t_hold();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule